// File: doc/BRIEF.md
# Processor Status Word Unit

This block keeps the 16-bit status word of a processor core. The low byte carries the classic arithmetic and control flags. The high byte carries the extended flags: a signed greater-or-equal flag, an odd/even flag, the privilege-mode bit and a two-bit return-frame size code. The block takes ALU results and their flag strobes, and keeps the flags current at the operand width of each operation (8, 16, 32 or 64 bits, limited to the datapath width).

The block also prepares the image that is written to the stack for a byte-wide flag push, a word-wide flag push and a full exception frame. It restores the status from a popped image. When a return instruction pops an exception frame, the block checks where the frame came from. If a frame from the user stack claims privileged mode, the block rejects it and raises an abort. Otherwise it reports the size of the return address to be read, as a byte count.

Top module: `status_word_unit`

## Requirements
- R1: After reset the status word is 0x0900: privileged bit (bit 11) is 1, frame size code (bits 9:8) is 01, and every other bit is 0. The abort and return-valid outputs are 0.
- R2: When `upd_nz_i` is high, N (bit 7) takes the top bit of the result at the selected operand width, Z (bit 1) is set when all result bits within that width are zero, and the odd flag OE (bit 14) takes result bit 0. Result bits above the width have no effect. The width code `op_size_i` is 0=8, 1=16, 2=32, 3=64, clipped to `DATA_W`.
- R3: C (bit 0) and V (bit 6) change only in a cycle where their own strobe is high, and then take the supplied value.
- R4: G (bit 15) is loaded only for class SBC (`op_cls_i`=2), with NOT(N xor V) of the new flags, and for class CMP (3), with the signed comparison opa >= opb at the operand width. Classes 0 and 1 leave G unchanged.
- R5: Status bits 5 and 4 and extended bits 13, 12 and 10 always read 0.
- R6: The push image for `push_kind_i`=0 (byte) is the low byte with bit 5 at 0 and bit 4 equal to `push_brk_i`, and a zero high byte. For kind 1 (word), the high byte holds only G and OE. For kind 2 (frame), the high byte holds G, OE, the privileged bit and the size code. The image is combinational from the current status.
- R7: A byte pull (`pull_kind_i`=0) restores N, V, D, I, Z and C. A word pull (1) also restores G and OE. Neither pull changes the privileged bit or the size code.
- R8: A frame pull (`pull_kind_i`=2) with `pull_user_i` high and popped bit 11 set leaves the status unchanged. One cycle later `priv_abort_o` pulses high for one cycle, and `ret_valid_o` stays low.
- R9: Any other frame pull restores all status fields. One cycle later `ret_valid_o` pulses high, and `ret_bytes_o` holds the return-address size from the popped code: 01=2, 10=4, 11=8, and 00=`NATIVE_W`/8.
- R10: An accepted pull in the same cycle as ALU strobes wins, and the ALU strobes are ignored. A rejected frame pull lets the ALU strobes of that cycle take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_size_i | input | 2 | Operand width code |
| res_i | input | DATA_W | ALU result |
| opa_i | input | DATA_W | First compare operand |
| opb_i | input | DATA_W | Second compare operand |
| op_cls_i | input | 2 | Operation class: 0 other, 1 load, 2 SBC, 3 CMP |
| upd_nz_i | input | 1 | Update N, Z and OE |
| upd_c_i | input | 1 | Update C |
| c_i | input | 1 | New carry value |
| upd_v_i | input | 1 | Update V |
| v_i | input | 1 | New overflow value |
| push_kind_i | input | 2 | Push image kind: 0 byte, 1 word, 2 frame |
| push_brk_i | input | 1 | Value for the break bit in the push image |
| pull_i | input | 1 | Pull request |
| pull_kind_i | input | 2 | Pull kind: 0 byte, 1 word, 2 frame |
| pull_user_i | input | 1 | Popped image comes from the user stack |
| pull_data_i | input | 16 | Popped image |
| status_o | output | 16 | Current status word |
| push_img_o | output | 16 | Image to push |
| ret_bytes_o | output | 4 | Return-address size in bytes |
| ret_valid_o | output | 1 | Pulse: frame accepted |
| priv_abort_o | output | 1 | Pulse: privilege-violation abort |

## Verification
A pull and an ALU flag update can arrive in the same cycle. The bench strobes both together: a byte pull of zero together with a carry set and a negative result. It expects only the pulled value in the status. It then repeats the case with a frame pull that must be rejected, and expects the abort pulse together with the carry set by the ALU. A second overlap, the SBC overflow strobe feeding the G flag in the same cycle as N, is judged by checking G against the newly written N and V.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_LOAD = 2'd1,
        CLS_SBC  = 2'd2,
        CLS_CMP  = 2'd3
    } op_cls_e;

    typedef enum logic [1:0] {
        XK_BYTE  = 2'd0,
        XK_WORD  = 2'd1,
        XK_FRAME = 2'd2,
        XK_NONE  = 2'd3
    } xfer_kind_e;

    // live flag set (reserved bits are not stored)
    typedef struct packed {
        logic       g;
        logic       oe;
        logic       h;
        logic [1:0] sf;
        logic       n;
        logic       v;
        logic       d;
        logic       i;
        logic       z;
        logic       c;
    } psw_t;

    // 16-bit image layout, bit 15 first; positions are behaviour
    typedef struct packed {
        logic       g;     // 15
        logic       oe;    // 14
        logic [1:0] r54;   // 13:12
        logic       h;     // 11
        logic       r2;    // 10
        logic [1:0] sf;    // 9:8
        logic       n;     // 7
        logic       v;     // 6
        logic       r5;    // 5
        logic       b;     // 4
        logic       d;     // 3
        logic       i;     // 2
        logic       z;     // 1
        logic       c;     // 0
    } img_t;

    localparam psw_t PSW_RESET = '{g: 1'b0, oe: 1'b0, h: 1'b1, sf: 2'b01,
                                   n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b0,
                                   z: 1'b0, c: 1'b0};

endpackage

// File: rtl/psw_alu_flags.sv
module psw_alu_flags #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        op_size_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              n_o,
    output logic              z_o,
    output logic              oe_o,
    output logic              ge_o
);
    logic [DATA_W-1:0] in_rng;
    logic [DATA_W-1:0] a_x;
    logic [DATA_W-1:0] b_x;
    logic              sa;
    logic              sb;
    int                w;

    always_comb begin
        w = 8 << op_size_i;
        if (w > DATA_W) w = DATA_W;
        n_o = 1'b0;
        sa  = 1'b0;
        sb  = 1'b0;
        for (int k = 0; k < DATA_W; k++) begin
            in_rng[k] = (k < w);
            if (k == w - 1) begin
                n_o = res_i[k];
                sa  = opa_i[k];
                sb  = opb_i[k];
            end
        end
        for (int k = 0; k < DATA_W; k++) begin
            a_x[k] = in_rng[k] ? opa_i[k] : sa;
            b_x[k] = in_rng[k] ? opb_i[k] : sb;
        end
        z_o  = ((res_i & in_rng) == '0);
        oe_o = res_i[0];
        ge_o = ($signed(a_x) >= $signed(b_x));
    end
endmodule

// File: rtl/psw_frame_check.sv
module psw_frame_check #(
    parameter int NATIVE_W = 32
) (
    input  logic       frame_i,
    input  logic       user_i,
    input  logic       h_i,
    input  logic [1:0] sf_i,
    output logic       reject_o,
    output logic [3:0] bytes_o
);
    localparam int         NATIVE_BYTES = NATIVE_W / 8;
    localparam logic [3:0] NB           = 4'(NATIVE_BYTES);

    always_comb begin
        reject_o = frame_i & user_i & h_i;
        unique case (sf_i)
            2'b01:   bytes_o = 4'd2;
            2'b10:   bytes_o = 4'd4;
            2'b11:   bytes_o = 4'd8;
            default: bytes_o = NB;
        endcase
    end
endmodule

// File: rtl/psw_push_fmt.sv
module psw_push_fmt
    import psw_pkg::*;
(
    input  psw_t       psw_i,
    input  logic [1:0] kind_i,
    input  logic       brk_i,
    output logic [15:0] img_o
);
    img_t im;

    always_comb begin
        im   = '0;
        im.n = psw_i.n;
        im.v = psw_i.v;
        im.b = brk_i;
        im.d = psw_i.d;
        im.i = psw_i.i;
        im.z = psw_i.z;
        im.c = psw_i.c;
        unique case (xfer_kind_e'(kind_i))
            XK_BYTE: ;
            XK_WORD: begin
                im.g  = psw_i.g;
                im.oe = psw_i.oe;
            end
            XK_FRAME: begin
                im.g  = psw_i.g;
                im.oe = psw_i.oe;
                im.h  = psw_i.h;
                im.sf = psw_i.sf;
            end
            default: im = '0;
        endcase
        img_o = im;
    end
endmodule

// File: rtl/status_word_unit.sv
module status_word_unit
    import psw_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NATIVE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_size_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [1:0]        op_cls_i,
    input  logic              upd_nz_i,
    input  logic              upd_c_i,
    input  logic              c_i,
    input  logic              upd_v_i,
    input  logic              v_i,
    input  logic [1:0]        push_kind_i,
    input  logic              push_brk_i,
    input  logic              pull_i,
    input  logic [1:0]        pull_kind_i,
    input  logic              pull_user_i,
    input  logic [15:0]       pull_data_i,
    output logic [15:0]       status_o,
    output logic [15:0]       push_img_o,
    output logic [3:0]        ret_bytes_o,
    output logic              ret_valid_o,
    output logic              priv_abort_o
);
    typedef struct packed {
        psw_t       psw;
        logic [3:0] rbytes;
        logic       rvalid;
        logic       abort;
    } state_t;

    state_t st_d, st_q;

    logic       alu_n, alu_z, alu_oe, alu_ge;
    logic       rej;
    logic [3:0] fr_bytes;
    img_t       pin;
    img_t       sout;
    xfer_kind_e pk;
    psw_t       alu_psw, pull_psw;
    logic       pull_taken;

    assign pin = img_t'(pull_data_i);
    assign pk  = xfer_kind_e'(pull_kind_i);

    psw_alu_flags #(.DATA_W(DATA_W)) u_alu (
        .op_size_i (op_size_i),
        .res_i     (res_i),
        .opa_i     (opa_i),
        .opb_i     (opb_i),
        .n_o       (alu_n),
        .z_o       (alu_z),
        .oe_o      (alu_oe),
        .ge_o      (alu_ge)
    );

    psw_frame_check #(.NATIVE_W(NATIVE_W)) u_frm (
        .frame_i  (pull_i && pk == XK_FRAME),
        .user_i   (pull_user_i),
        .h_i      (pin.h),
        .sf_i     (pin.sf),
        .reject_o (rej),
        .bytes_o  (fr_bytes)
    );

    psw_push_fmt u_push (
        .psw_i  (st_q.psw),
        .kind_i (push_kind_i),
        .brk_i  (push_brk_i),
        .img_o  (push_img_o)
    );

    always_comb begin
        // ALU path
        alu_psw = st_q.psw;
        if (upd_nz_i) begin
            alu_psw.n  = alu_n;
            alu_psw.z  = alu_z;
            alu_psw.oe = alu_oe;
        end
        if (upd_c_i) alu_psw.c = c_i;
        if (upd_v_i) alu_psw.v = v_i;
        unique case (op_cls_e'(op_cls_i))
            CLS_SBC: alu_psw.g = ~(alu_psw.n ^ alu_psw.v);
            CLS_CMP: alu_psw.g = alu_ge;
            default: ;
        endcase

        // pull path
        pull_psw   = st_q.psw;
        pull_psw.n = pin.n;
        pull_psw.v = pin.v;
        pull_psw.d = pin.d;
        pull_psw.i = pin.i;
        pull_psw.z = pin.z;
        pull_psw.c = pin.c;
        if (pk == XK_WORD || pk == XK_FRAME) begin
            pull_psw.g  = pin.g;
            pull_psw.oe = pin.oe;
        end
        if (pk == XK_FRAME) begin
            pull_psw.h  = pin.h;
            pull_psw.sf = pin.sf;
        end
        pull_taken = pull_i && (pk != XK_NONE) && !rej;

        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.abort  = rej;
        st_d.psw    = pull_taken ? pull_psw : alu_psw;
        if (pull_taken && pk == XK_FRAME) begin
            st_d.rvalid = 1'b1;
            st_d.rbytes = fr_bytes;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.psw    <= PSW_RESET;
            st_q.rbytes <= '0;
            st_q.rvalid <= 1'b0;
            st_q.abort  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        sout    = '0;
        sout.g  = st_q.psw.g;
        sout.oe = st_q.psw.oe;
        sout.h  = st_q.psw.h;
        sout.sf = st_q.psw.sf;
        sout.n  = st_q.psw.n;
        sout.v  = st_q.psw.v;
        sout.d  = st_q.psw.d;
        sout.i  = st_q.psw.i;
        sout.z  = st_q.psw.z;
        sout.c  = st_q.psw.c;
    end

    assign status_o     = sout;
    assign ret_bytes_o  = st_q.rbytes;
    assign ret_valid_o  = st_q.rvalid;
    assign priv_abort_o = st_q.abort;
endmodule

// File: rtl/psw_checker.sv
module psw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        upd_nz_i,
    input logic        upd_c_i,
    input logic        upd_v_i,
    input logic        pull_i,
    input logic [1:0]  pull_kind_i,
    input logic        pull_user_i,
    input logic [15:0] pull_data_i,
    input logic [15:0] status_o,
    input logic [3:0]  ret_bytes_o,
    input logic        ret_valid_o,
    input logic        priv_abort_o
);
    p_abort_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_i && pull_kind_i == 2'd2 && pull_user_i && pull_data_i[11])
        |=> (priv_abort_o && !ret_valid_o));

    p_abort_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_i && pull_kind_i == 2'd2 && pull_user_i && pull_data_i[11]
         && !upd_nz_i && !upd_c_i && !upd_v_i)
        |=> $stable(status_o));

    p_ret_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_o |-> ($countones(ret_bytes_o) == 1));

    p_c_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_c_i && !pull_i) |=> $stable(status_o[0]));

    p_v_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_v_i && !pull_i) |=> $stable(status_o[6]));

    p_nz_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_nz_i && !pull_i) |=> ($stable(status_o[7]) && $stable(status_o[1])));

    p_word_pull_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_i && pull_kind_i == 2'd1) |=> $stable(status_o[11:8]));
endmodule

bind status_word_unit psw_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_nz_i     (upd_nz_i),
    .upd_c_i      (upd_c_i),
    .upd_v_i      (upd_v_i),
    .pull_i       (pull_i),
    .pull_kind_i  (pull_kind_i),
    .pull_user_i  (pull_user_i),
    .pull_data_i  (pull_data_i),
    .status_o     (status_o),
    .ret_bytes_o  (ret_bytes_o),
    .ret_valid_o  (ret_valid_o),
    .priv_abort_o (priv_abort_o)
);

// File: tb/sim_status_word_unit.sv
`timescale 1ns/1ps
module sim_status_word_unit;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    op_size_i;
    logic [DW-1:0] res_i, opa_i, opb_i;
    logic [1:0]    op_cls_i;
    logic          upd_nz_i, upd_c_i, c_i, upd_v_i, v_i;
    logic [1:0]    push_kind_i;
    logic          push_brk_i;
    logic          pull_i;
    logic [1:0]    pull_kind_i;
    logic          pull_user_i;
    logic [15:0]   pull_data_i;
    logic [15:0]   status_o, push_img_o;
    logic [3:0]    ret_bytes_o;
    logic          ret_valid_o, priv_abort_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    status_word_unit #(.DATA_W(DW), .NATIVE_W(32)) u0 (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        op_size_i = 2'd0; res_i = '0; opa_i = '0; opb_i = '0; op_cls_i = 2'd0;
        upd_nz_i = 1'b0; upd_c_i = 1'b0; c_i = 1'b0; upd_v_i = 1'b0; v_i = 1'b0;
        push_kind_i = 2'd0; push_brk_i = 1'b0;
        pull_i = 1'b0; pull_kind_i = 2'd0; pull_user_i = 1'b0; pull_data_i = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic alu(input logic [1:0] cls, input logic [1:0] sz, input logic [DW-1:0] r,
                       input logic nz, input logic uc, input logic cv,
                       input logic uv, input logic vv);
        op_cls_i = cls; op_size_i = sz; res_i = r; upd_nz_i = nz;
        upd_c_i = uc; c_i = cv; upd_v_i = uv; v_i = vv;
        tick();
        idle();
    endtask

    task automatic pull(input logic [1:0] kind, input logic user, input logic [15:0] d);
        pull_i = 1'b1; pull_kind_i = kind; pull_user_i = user; pull_data_i = d;
        tick();
        idle();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 status", status_o, 16'h0900);
        chk("R1 abort", {15'd0, priv_abort_o}, 16'h0);
        chk("R1 ret_valid", {15'd0, ret_valid_o}, 16'h0);
    endtask

    task automatic t_nzoe();
        do_reset();
        alu(2'd1, 2'd0, 32'h80, 1, 0, 0, 0, 0);
        chk("R2 neg 8b", status_o, 16'h0980);
        alu(2'd1, 2'd0, 32'h100, 1, 0, 0, 0, 0);
        chk("R2 zero 8b upper ignored", status_o, 16'h0902);
        alu(2'd1, 2'd1, 32'h0003, 1, 0, 0, 0, 0);
        chk("R2 odd 16b", status_o, 16'h4900);
        alu(2'd1, 2'd1, 32'h8001, 1, 0, 0, 0, 0);
        chk("R2 neg odd 16b", status_o, 16'h4980);
        alu(2'd1, 2'd3, 32'h8000_0000, 1, 0, 0, 0, 0);
        chk("R2 clipped width", status_o, 16'h0980);
    endtask

    task automatic t_cv();
        do_reset();
        alu(2'd0, 2'd0, '0, 0, 1, 1, 0, 0);
        chk("R3 carry set", status_o, 16'h0901);
        alu(2'd0, 2'd0, '0, 0, 0, 0, 1, 1);
        chk("R3 overflow set", status_o, 16'h0941);
        alu(2'd0, 2'd0, '0, 0, 0, 0, 0, 0);
        chk("R3 no strobe no change", status_o, 16'h0941);
    endtask

    task automatic t_g();
        do_reset();
        alu(2'd2, 2'd0, 32'hFF, 1, 1, 0, 1, 0);
        chk("R4 sbc less", status_o, 16'h4980);
        alu(2'd2, 2'd0, 32'h80, 1, 1, 0, 1, 1);
        chk("R4 sbc ge", status_o, 16'h89C0);
        opa_i = 32'h80; opb_i = 32'h01;
        op_cls_i = 2'd3; op_size_i = 2'd0; res_i = 32'h7F; upd_nz_i = 1'b1;
        upd_c_i = 1'b1; c_i = 1'b1;
        tick(); idle();
        chk("R4 cmp signed less 8b", status_o, 16'h4941);
        opa_i = 32'h0080; opb_i = 32'h0001;
        op_cls_i = 2'd3; op_size_i = 2'd1; res_i = 32'h007F; upd_nz_i = 1'b1;
        upd_c_i = 1'b1; c_i = 1'b1;
        tick(); idle();
        chk("R4 cmp ge 16b", status_o, 16'hC941);
        alu(2'd1, 2'd0, 32'h0, 1, 0, 0, 0, 0);
        chk("R4 load keeps G", status_o, 16'h8943);
    endtask

    task automatic t_push();
        do_reset();
        alu(2'd2, 2'd0, 32'h81, 1, 0, 0, 1, 1);
        chk("R4 setup", status_o, 16'hC9C0);
        chk("R5 reserved zero", status_o & 16'h3430, 16'h0000);
        push_kind_i = 2'd0; push_brk_i = 1'b1; #1;
        chk("R6 byte push", push_img_o, 16'h00D0);
        push_kind_i = 2'd1; push_brk_i = 1'b0; #1;
        chk("R6 word push", push_img_o, 16'hC0C0);
        push_kind_i = 2'd2; #1;
        chk("R6 frame push", push_img_o, 16'hC9C0);
        idle();
    endtask

    task automatic t_pull();
        do_reset();
        pull(2'd0, 1'b0, 16'hFFFF);
        chk("R7 byte pull", status_o, 16'h09CF);
        chk("R5 reserved after pull", status_o & 16'h3430, 16'h0000);
        pull(2'd1, 1'b0, 16'hFF3C);
        chk("R7 word pull", status_o, 16'hC90C);
    endtask

    task automatic t_frame();
        do_reset();
        pull(2'd2, 1'b1, 16'h0800);
        chk("R8 status kept", status_o, 16'h0900);
        chk("R8 abort", {15'd0, priv_abort_o}, 16'h1);
        chk("R8 no ret_valid", {15'd0, ret_valid_o}, 16'h0);
        tick();
        chk("R8 abort one cycle", {15'd0, priv_abort_o}, 16'h0);
        pull(2'd2, 1'b1, 16'h4283);
        chk("R9 user frame ok", status_o, 16'h4283);
        chk("R9 valid", {15'd0, ret_valid_o}, 16'h1);
        chk("R9 size 4", {12'd0, ret_bytes_o}, 16'h4);
        tick();
        chk("R9 valid one cycle", {15'd0, ret_valid_o}, 16'h0);
        pull(2'd2, 1'b0, 16'h0B00);
        chk("R9 hyp frame H", status_o, 16'h0B00);
        chk("R9 size 8", {12'd0, ret_bytes_o}, 16'h8);
        pull(2'd2, 1'b1, 16'h0100);
        chk("R9 size 2", {12'd0, ret_bytes_o}, 16'h2);
        pull(2'd2, 1'b0, 16'h8800);
        chk("R9 native size", {12'd0, ret_bytes_o}, 16'h4);
        chk("R9 native status", status_o, 16'h8800);
    endtask

    task automatic t_collide();
        do_reset();
        pull_i = 1'b1; pull_kind_i = 2'd0; pull_data_i = 16'h0000;
        upd_c_i = 1'b1; c_i = 1'b1; upd_nz_i = 1'b1; res_i = 32'h80; op_cls_i = 2'd1;
        tick(); idle();
        chk("R10 pull wins", status_o, 16'h0900);
        pull_i = 1'b1; pull_kind_i = 2'd2; pull_user_i = 1'b1; pull_data_i = 16'h0800;
        upd_c_i = 1'b1; c_i = 1'b1;
        tick(); idle();
        chk("R10 rejected pull keeps alu", status_o, 16'h0901);
        chk("R10 abort", {15'd0, priv_abort_o}, 16'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle();
        t_reset();
        t_nzoe();
        t_cv();
        t_g();
        t_push();
        t_pull();
        t_frame();
        t_collide();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule